// File: doc/BRIEF.md
# Peripheral Interrupt Flag Bank

This block holds a small bank of interrupt flags raised by on-chip peripherals of a microcontroller. Each flag has a matching enable bit that arrives from a separate enable register outside the block. Software reads and writes the flag bank over a simple register port. Peripherals set or clear individual flags through per-bit hardware strobes. A single generic trigger input sets one preselected flag.

Two parameter masks divide the bits. The writable mask lists the bits that software may change. The valid mask lists the bits that count toward the interrupt-status output. Some flags are valid but read-only to software. In the default build these are the serial transmit-ready flag (bit 4) and the serial receive-full flag (bit 5). They follow the serial buffers and change only through the hardware strobes. A third mask lists the bits that hardware may clear.

Every update that can raise a flag is checked against the enables: a software write, a trigger or a hardware set. If the updated flags AND the enables are nonzero, the block emits a one-cycle peripheral-interrupt request. It also drives a level interrupt-status output.

Top module: `pirq_flag_bank`

## Requirements
- R1: While reset is high, at the clock edge the flags go to 0 and the request output goes to 0.
- R2: A software write stores `(wr_data & WRITE_MASK) | (flags & ~WRITE_MASK)`. `rd_data` always shows every flag bit, read-only bits included.
- R3: Bits outside WRITE_MASK ignore software writes. In the default build these are bit 4 (transmit-ready) and bit 5 (receive-full). They change only through `hw_set` and `hw_clr`.
- R4: A `hw_clr` bit clears its flag only when the bit is in CLEAR_MASK. The default CLEAR_MASK is bit 3 (synchronous serial), bit 4 and bit 5. Other `hw_clr` bits have no effect.
- R5: `irq_req` is high for one cycle, in the cycle the updated flags first appear on `rd_data`, when both of these hold: the update involved a software write, a trigger or an honoured hardware set; and the new flags AND `irq_enable` are nonzero. The valid mask does not take part in this check.
- R6: An update made only by hardware clears never raises `irq_req`.
- R7: `irq_status` equals `|(flags & VALID_MASK & irq_enable)`. It follows `irq_enable` in the same cycle.
- R8: A `trigger` pulse acts like a software write of `flags | TRIG_MASK`. TRIG_MASK must be one-hot.
- R9: When several sources act on the same bit in one cycle, the priority per bit is: hardware set first, then hardware clear, then trigger, then software write.
- R10: A `hw_set` bit sets its flag only when the bit is in VALID_MASK. Other `hw_set` bits have no effect and are not a request cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | W | Software write data |
| rd_data | output | W | Current flag value |
| irq_enable | input | W | Per-bit enables from the companion enable register |
| hw_set | input | W | Per-bit hardware set strobes |
| hw_clr | input | W | Per-bit hardware clear strobes |
| trigger | input | 1 | Generic trigger; sets the TRIG_MASK flag |
| irq_req | output | 1 | One-cycle peripheral-interrupt request |
| irq_status | output | 1 | Level: a valid, enabled flag is set |

## Verification
The bench builds the block with VALID_MASK = 8'h7F, WRITE_MASK = 8'hCF, CLEAR_MASK = 8'h38 and TRIG_MASK = 8'h04. In this build bit 7 is writable but not valid. This lets one stimulus show that the request check ignores the valid mask while the status output applies it. It also lets the bench confirm that a hardware set of a non-valid bit is dropped. The trigger lands on a writable bit that is not bit 0, so the bench can race it against a write that clears the same bit.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // Which kind of update reached the flag register this cycle.
  typedef struct packed {
    logic sw_write;
    logic trig;
    logic hw_set;
    logic hw_clr;
  } pirq_cause_t;

  // Merge a write value into a register through a mask.
  function automatic logic [63:0] masked_merge(input logic [63:0] old_v,
                                               input logic [63:0] new_v,
                                               input logic [63:0] mask);
    return (new_v & mask) | (old_v & ~mask);
  endfunction
endpackage

// File: rtl/pirq_next.sv
module pirq_next #(
  parameter int          W          = 8,
  parameter logic [W-1:0] VALID_MASK = '1,
  parameter logic [W-1:0] WRITE_MASK = '1,
  parameter logic [W-1:0] CLEAR_MASK = '1,
  parameter logic [W-1:0] TRIG_MASK  = 1
) (
  input  logic [W-1:0] cur,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  input  logic         trigger,
  output logic [W-1:0] nxt,
  output pirq_pkg::pirq_cause_t cause
);
  localparam logic [W-1:0] TRIG_EFF = TRIG_MASK & WRITE_MASK;

  logic [W-1:0] set_ok, clr_ok, trig_ok;
  assign set_ok  = hw_set & VALID_MASK;
  assign clr_ok  = hw_clr & CLEAR_MASK;
  assign trig_ok = trigger ? TRIG_EFF : '0;

  always_comb begin
    cause.sw_write = wr_en;
    cause.trig     = trigger;
    cause.hw_set   = |set_ok;
    cause.hw_clr   = |clr_ok;
  end

  // Per-bit priority: hw set, hw clear, trigger, software write.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic wr_bit;
    always_comb begin
      if (wr_en && WRITE_MASK[i]) wr_bit = wr_data[i];
      else                        wr_bit = cur[i];
      if (set_ok[i])       nxt[i] = 1'b1;
      else if (clr_ok[i])  nxt[i] = 1'b0;
      else if (trig_ok[i]) nxt[i] = 1'b1;
      else                 nxt[i] = wr_bit;
    end
  end
endmodule

// File: rtl/pirq_req.sv
module pirq_req #(
  parameter int          W          = 8,
  parameter logic [W-1:0] VALID_MASK = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          nxt,
  input  logic [W-1:0]          flags,
  input  logic [W-1:0]          irq_enable,
  input  pirq_pkg::pirq_cause_t cause,
  output logic                  irq_req,
  output logic                  irq_status
);
  logic raise;
  assign raise = cause.sw_write | cause.trig | cause.hw_set;

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= raise && ((nxt & irq_enable) != '0);
  end

  assign irq_status = |(flags & VALID_MASK & irq_enable);

  // R5: a request only follows a raising update.
  assert_req_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(raise));
  // R6: clears alone never request.
  assert_clear_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (cause.hw_clr && !raise) |=> !irq_req);
endmodule

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank #(
  parameter int          W          = 8,
  parameter logic [W-1:0] VALID_MASK = 8'hFF,
  parameter logic [W-1:0] WRITE_MASK = 8'hCF,
  parameter logic [W-1:0] CLEAR_MASK = 8'h38,
  parameter logic [W-1:0] TRIG_MASK  = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] irq_enable,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  input  logic         trigger,
  output logic         irq_req,
  output logic         irq_status
);
  if (TRIG_MASK == '0 || (TRIG_MASK & (TRIG_MASK - 1'b1)) != '0) begin : g_bad_trig
    $error("TRIG_MASK must be one-hot");
  end

  logic [W-1:0]          flags, nxt;
  pirq_pkg::pirq_cause_t cause;

  pirq_next #(
    .W(W), .VALID_MASK(VALID_MASK), .WRITE_MASK(WRITE_MASK),
    .CLEAR_MASK(CLEAR_MASK), .TRIG_MASK(TRIG_MASK)
  ) u_next (
    .cur(flags), .wr_en(wr_en), .wr_data(wr_data), .hw_set(hw_set),
    .hw_clr(hw_clr), .trigger(trigger), .nxt(nxt), .cause(cause)
  );

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nxt;
  end

  assign rd_data = flags;

  pirq_req #(.W(W), .VALID_MASK(VALID_MASK)) u_req (
    .clk(clk), .rst(rst), .nxt(nxt), .flags(flags), .irq_enable(irq_enable),
    .cause(cause), .irq_req(irq_req), .irq_status(irq_status)
  );

  // R3: a lone write leaves non-writable bits alone.
  assert_ro_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !trigger && hw_set == '0 && hw_clr == '0)
      |=> ((rd_data & ~WRITE_MASK) == ($past(rd_data) & ~WRITE_MASK)));
  // R9: an honoured hardware set always lands.
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rd_data & $past(hw_set & VALID_MASK)) == $past(hw_set & VALID_MASK)));
endmodule

// File: tb/pirq_flag_bank_bench.sv
module pirq_flag_bank_bench;
  localparam int W = 8;
  localparam logic [W-1:0] VM = 8'h7F, WM = 8'hCF, CM = 8'h38, TM = 8'h04;

  logic clk = 0, rst = 1, wr_en = 0, trigger = 0;
  logic [W-1:0] wr_data = 0, irq_enable = 0, hw_set = 0, hw_clr = 0;
  logic [W-1:0] rd_data;
  logic irq_req, irq_status;

  always #4 clk = ~clk;

  pirq_flag_bank #(.W(W), .VALID_MASK(VM), .WRITE_MASK(WM), .CLEAR_MASK(CM),
                   .TRIG_MASK(TM)) u_pirq_flag_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_enable(irq_enable), .hw_set(hw_set), .hw_clr(hw_clr), .trigger(trigger),
    .irq_req(irq_req), .irq_status(irq_status)
  );

  typedef struct {
    int stamp; logic [W-1:0] f; logic rq; logic st; string tag;
  } exp_t;
  exp_t q[$];

  int cyc = 0, tests = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] model = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare items whose update edge has passed.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (rd_data !== e.f || irq_req !== e.rq || irq_status !== e.st) begin
        fails++;
        $display("FAIL %s: got flags=%h req=%b st=%b exp flags=%h req=%b st=%b",
                 e.tag, rd_data, irq_req, irq_status, e.f, e.rq, e.st);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic op(input string tag, input logic w, input logic [W-1:0] wd,
                    input logic [W-1:0] s, input logic [W-1:0] c,
                    input logic t, input logic [W-1:0] en);
    exp_t e;
    logic [W-1:0] nx;
    logic rq;
    @(negedge clk); #1;
    wr_en = w; wr_data = wd; hw_set = s; hw_clr = c; trigger = t; irq_enable = en;
    nx = model;
    if (w) nx = (wd & WM) | (nx & ~WM);
    if (t) nx = nx | (TM & WM);
    nx = nx & ~(c & CM);
    nx = nx | (s & VM);
    rq = (w || t || ((s & VM) != 0)) && ((nx & en) != 0);
    model = nx;
    e.stamp = cyc; e.f = nx; e.rq = rq; e.st = |(nx & VM & en); e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst = 0;
        op("R1 reset state", 0, 0, 0, 0, 0, 8'hFF);
        op("R2 masked write", 1, 8'hFF, 0, 0, 0, 8'h00);
        op("R2 write zeros", 1, 8'h00, 0, 0, 0, 8'hFF);
        op("R3 hw set ro bits R5", 0, 0, 8'h30, 0, 0, 8'h10);
        op("R3 write ignores ro", 1, 8'h00, 0, 0, 0, 8'h10);
        op("R2 write bit0", 1, 8'h01, 0, 0, 0, 8'h00);
        op("R4 R6 clear mask", 0, 0, 0, 8'h31, 0, 8'hFF);
        op("R5 R7 nonvalid write", 1, 8'h80, 0, 0, 0, 8'h80);
        op("R10 nonvalid set", 0, 0, 8'h80, 0, 0, 8'h80);
        op("R8 trigger", 0, 0, 0, 0, 1, 8'h04);
        op("R9 trig over write", 1, 8'h00, 0, 0, 1, 8'h04);
        op("R9 set over clear", 1, 8'h00, 8'h08, 8'h08, 0, 8'h08);
        op("R9 clear over write", 1, 8'h08, 0, 8'h08, 0, 8'h08);
        op("R7 disabled status", 1, 8'h01, 0, 0, 0, 8'h00);
        op("R7 enable follows", 0, 0, 0, 0, 0, 8'h01);
        op("R6 ro clear silent", 0, 0, 8'h10, 0, 0, 8'h00);
        op("R6 clear tx", 0, 0, 0, 8'h10, 0, 8'hFF);
        op("R1 idle", 0, 0, 0, 0, 0, 8'hFF);
        repeat (3) @(negedge clk);
        done = 1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          tests++; fails++;
          $display("FAIL watchdog: got timeout exp completion");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule